// File: doc/BRIEF.md
# Byte-Lane Banked Memory with Unaligned Single-Cycle Access

This block is a byte-addressable memory that reads or writes any 32-bit word in one cycle, whatever the word's alignment. The storage is split into four byte-wide banks. Each bank serves one lane of the 32-bit data port. The low two address bits give the byte offset, and the bits above them give the bank row. When the offset is zero, all four banks use the same row. When the offset is non-zero, the banks whose lane index is below the offset add one to their row. This lets a word that crosses a row boundary be assembled from two rows at once.

Write data and byte enables are rotated onto the lanes by the offset. Read data is rotated back, so the byte at the requested address always appears in bits 7:0 (little-endian). Every request gets a response one cycle later. For a write, that response carries the four bytes as they were before the write.

An unaligned access at the last row would need a row beyond the end of storage. Such an access raises an error flag with its response, returns zero data and changes no byte.

Top module: `lane_mem`

## Requirements
- R1: After reset, and until the first request, rvalid_o and err_o are 0 and rdata_o is 0.
- R2: Every cycle with req_i high produces rvalid_o high in the next cycle. A cycle with req_i low produces rvalid_o low in the next cycle.
- R3: An aligned read (addr_i[1:0] = 0) returns, one cycle later, the byte at address addr_i+i in rdata_o bits 8i+7:8i, for i = 0..3.
- R4: A read with byte offset 1, 2 or 3 completes in a single cycle with the same byte ordering as R3, even when its bytes span two rows. Lane k uses row+1 exactly when k is less than the offset.
- R5: A write stores byte i of wdata_i (bits 8i+7:8i) at address addr_i+i when be_i[i] is 1. When be_i[i] is 0, that byte is left unchanged.
- R6: The response to a write (we_i = 1) returns in rdata_o the four bytes at addr_i..addr_i+3 as they were before the write.
- R7: An access with a non-zero offset whose row is the last row (ROWS-1) sets err_o together with its rvalid_o. Its rdata_o is 0 and no byte of memory is written.
- R8: An aligned access to the last row is served normally, with err_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | $clog2(ROWS)+2 | Byte address; bits 1:0 are the byte offset, the upper bits are the row |
| wdata_i | input | 32 | Write word, little-endian from addr_i |
| be_i | input | 4 | Byte enables, bit i controls the byte at addr_i+i |
| rdata_o | output | 32 | Read word, little-endian from the address of the request |
| rvalid_o | output | 1 | Response valid, one cycle after req_i |
| err_o | output | 1 | Response is an out-of-range unaligned access |

## Verification
Two functions always meet in one cycle on a write: the banks return their old bytes, and in the same edge they store the new ones. The rotated write path and the rotated read path therefore act on the same lanes together. The bench provokes this with unaligned writes under random byte enables over a memory it has filled first. It judges the response against the model's contents taken before the write is applied, and later reads confirm the update. The error path is the other overlap: an unaligned access at the last row both flags the error and blocks its write. The bench sends such writes with full enables and then reads the last row aligned, expecting the earlier contents.

// File: rtl/lane_mem_pkg.sv
package lane_mem_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int WORD_W = LANES * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [OFF_W-1:0]  off_t;
endpackage

// File: rtl/lane_mem_bank.sv
module lane_mem_bank #(
  parameter int ROWS  = 256,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic                      clk_i,
  input  logic                      en_i,
  input  logic                      we_i,
  input  logic [ROW_W-1:0]          row_i,
  input  logic                      inc_i,
  input  lane_mem_pkg::byte_t       d_i,
  output lane_mem_pkg::byte_t       q_o
);
  import lane_mem_pkg::*;

  byte_t            mem [ROWS];
  logic [ROW_W-1:0] row_eff;

  // caller guarantees row_i + inc_i < ROWS when en_i is high
  assign row_eff = row_i + ROW_W'(inc_i);

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      q_o <= mem[row_eff];
      if (we_i) mem[row_eff] <= d_i;
    end
  end
endmodule

// File: rtl/lane_mem_map.sv
module lane_mem_map #(
  parameter int ROWS  = 256,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic [ROW_W+1:0]                              addr_i,
  input  logic [lane_mem_pkg::WORD_W-1:0]               wdata_i,
  input  logic [lane_mem_pkg::LANES-1:0]                be_i,
  output logic [ROW_W-1:0]                              row_o,
  output lane_mem_pkg::off_t                            off_o,
  output logic [lane_mem_pkg::LANES-1:0]                inc_o,
  output lane_mem_pkg::byte_t [lane_mem_pkg::LANES-1:0] wbyte_o,
  output logic [lane_mem_pkg::LANES-1:0]                wbe_o,
  output logic                                          err_o
);
  import lane_mem_pkg::*;

  localparam logic [ROW_W:0] LIMIT = (ROW_W+1)'(ROWS);

  assign off_o = addr_i[OFF_W-1:0];
  assign row_o = addr_i[ROW_W+1:OFF_W];
  assign err_o = ({1'b0, row_o} + (ROW_W+1)'(off_o != '0)) >= LIMIT;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    off_t src;
    assign src        = off_t'(k) - off_o;   // logical byte index landing on lane k
    assign inc_o[k]   = off_t'(k) < off_o;
    assign wbyte_o[k] = wdata_i[src*BYTE_W +: BYTE_W];
    assign wbe_o[k]   = be_i[src];
  end
endmodule

// File: rtl/lane_mem.sv
module lane_mem #(
  parameter int ROWS  = 256,
  localparam int ROW_W = $clog2(ROWS),
  localparam int AW    = ROW_W + 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              req_i,
  input  logic                              we_i,
  input  logic [AW-1:0]                     addr_i,
  input  logic [lane_mem_pkg::WORD_W-1:0]   wdata_i,
  input  logic [lane_mem_pkg::LANES-1:0]    be_i,
  output logic [lane_mem_pkg::WORD_W-1:0]   rdata_o,
  output logic                              rvalid_o,
  output logic                              err_o
);
  import lane_mem_pkg::*;

  logic [ROW_W-1:0]   row;
  off_t               off, off_q;
  logic [LANES-1:0]   lane_inc, lane_be;
  byte_t [LANES-1:0]  lane_wd, lane_q;
  logic               map_err, bank_en;
  logic [WORD_W-1:0]  rot;

  lane_mem_map #(.ROWS(ROWS), .ROW_W(ROW_W)) u_map (
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .be_i   (be_i),
    .row_o  (row),
    .off_o  (off),
    .inc_o  (lane_inc),
    .wbyte_o(lane_wd),
    .wbe_o  (lane_be),
    .err_o  (map_err)
  );

  assign bank_en = req_i & ~map_err;

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    lane_mem_bank #(.ROWS(ROWS), .ROW_W(ROW_W)) u_bank (
      .clk_i(clk_i),
      .en_i (bank_en),
      .we_i (we_i & lane_be[k]),
      .row_i(row),
      .inc_i(lane_inc[k]),
      .d_i  (lane_wd[k]),
      .q_o  (lane_q[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
      off_q    <= '0;
    end else begin
      rvalid_o <= req_i;
      err_o    <= req_i & map_err;
      if (req_i) off_q <= off;
    end
  end

  // undo lane rotation: logical byte i sits on lane (i + offset)
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      rot[i*BYTE_W +: BYTE_W] = lane_q[off_t'(i) + off_q];
    end
  end

  assign rdata_o = (rvalid_o && !err_o) ? rot : '0;

  AST_RVALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rvalid_o); // R2
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rvalid_o); // R2
  AST_INC_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> $countones(lane_inc) == int'(addr_i[1:0])); // R4
  AST_ERR_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && addr_i[1:0] != 2'd0 && addr_i[AW-1:2] == ROW_W'(ROWS-1) |=> err_o); // R7
  AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rvalid_o && rdata_o == '0); // R7
  AST_ALIGNED_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && addr_i[1:0] == 2'd0 && int'(addr_i[AW-1:2]) < ROWS |=> !err_o); // R8
endmodule

// File: tb/sim_lane_mem.sv
`timescale 1ns/1ps
module sim_lane_mem;
  localparam int ROWS  = 256;
  localparam int AW    = $clog2(ROWS) + 2;
  localparam int BYTES = ROWS * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [3:0]    be = '0;
  logic [31:0]   rdata;
  logic          rvalid, err;

  int total = 0;
  int bad = 0;
  logic [7:0] model [BYTES];

  always #2.5 clk = ~clk;

  lane_mem #(.ROWS(ROWS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .rdata_o(rdata), .rvalid_o(rvalid), .err_o(err)
  );

  function automatic bit exp_err(int a);
    return (a % 4 != 0) && (a / 4 == ROWS - 1);
  endfunction

  function automatic logic [31:0] exp_word(int a);
    logic [31:0] w = '0;
    for (int i = 0; i < 4; i++) w[i*8 +: 8] = model[a + i];
    return w;
  endfunction

  task automatic check(string req_tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req_tag, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the response edge
  task automatic access(bit w, int a, logic [31:0] d, logic [3:0] e);
    bit          x = exp_err(a);
    logic [31:0] ex = x ? 32'h0 : exp_word(a);
    string       tag = x ? "R7" : (w ? "R6" : ((a % 4 == 0) ? "R3" : "R4"));
    req = 1'b1; we = w; addr = AW'(a); wdata = d; be = e;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check("R2", "rvalid", {31'b0, rvalid}, 32'd1);
    check(tag, "err", {31'b0, err}, {31'b0, x});
    check(tag, "rdata", rdata, ex);
    if (w && !x)
      for (int i = 0; i < 4; i++) if (e[i]) model[a + i] = d[i*8 +: 8];
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rvalid", {31'b0, rvalid}, 32'd0);
    check("R1", "err", {31'b0, err}, 32'd0);
    check("R1", "rdata", rdata, 32'd0);

    // fill: aligned full writes, response data ignored until known
    for (int r = 0; r < ROWS; r++) begin
      req = 1'b1; we = 1'b1; addr = AW'(r * 4); wdata = $urandom; be = 4'hf;
      for (int i = 0; i < 4; i++) model[r*4 + i] = wdata[i*8 +: 8];
      @(negedge clk);
    end
    req = 1'b0; we = 1'b0;
    @(negedge clk);
    check("R2", "idle rvalid", {31'b0, rvalid}, 32'd0);

    // R4: each offset straddling rows 5/6
    for (int o = 0; o < 4; o++) access(1'b0, 5*4 + o, 32'h0, 4'h0);
    // R5: partial enables, unaligned, then read back
    access(1'b1, 41, 32'hA1B2C3D4, 4'b0101);
    access(1'b0, 41, 32'h0, 4'h0);
    access(1'b1, 43, 32'h11223344, 4'b1010);
    access(1'b0, 40, 32'h0, 4'h0);
    access(1'b0, 44, 32'h0, 4'h0);
    // R8: aligned last row
    access(1'b0, (ROWS-1)*4, 32'h0, 4'h0);
    access(1'b1, (ROWS-1)*4, 32'hCAFEF00D, 4'hf);
    // R7: unaligned at last row blocks its write
    for (int o = 1; o < 4; o++) access(1'b1, (ROWS-1)*4 + o, 32'hDEADBEEF, 4'hf);
    access(1'b0, (ROWS-1)*4, 32'h0, 4'h0);
    access(1'b0, (ROWS-2)*4 + 3, 32'h0, 4'h0);

    // random mix, R3..R7
    for (int n = 0; n < 600; n++) begin
      access(1'($urandom_range(0, 1)), $urandom_range(0, BYTES - 1),
             $urandom, 4'($urandom_range(0, 15)));
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        check("R2", "gap rvalid", {31'b0, rvalid}, 32'd0);
      end
    end

    // final sweep reading every row at a random offset
    for (int r = 0; r < ROWS; r++) access(1'b0, r*4 + $urandom_range(0, 3), 32'h0, 4'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule